// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block is the station-management end of a two-wire management bus. It builds indirect-access frames and shifts them out on MDIO. The frames carry a register address, a write, a read, or a read that also advances the address. For read-type frames it captures the 16-bit register contents that the addressed device drives back.

The host supplies an opcode, a 5-bit port address, a 5-bit device address and a 16-bit payload, then pulses `start`. The block holds `busy` high until the frame is over, then pulses `done`. After a read, `rdata` holds the value taken from the line. The management clock `mdc` comes from the system clock, with a half-period of `HALF_DIV` system cycles, and it toggles only while a frame is in progress. The bidirectional pin is driven through `mdio_o` and `mdio_oe`, and sensed through `mdio_i`. Between frames the driver is off, so an external pull-up holds the line high.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset and between frames, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `mdio_o` is 1.
- R2: A frame is exactly 64 `mdc` periods. Each `mdc` half-period lasts `HALF_DIV` system clocks.
- R3: The first 32 bits of every frame are logic 1. They are followed by the start code 0,0.
- R4: After the start code, the 2-bit opcode is sent, then the 5-bit port address, then the 5-bit device address, each most significant bit first. The opcodes are 00 = address, 01 = write, 11 = read, 10 = read with post-increment.
- R5: For opcodes 00 and 01, the master drives 1 then 0 in the two turnaround bits. It then drives the 16-bit payload, bit 15 first, so `mdio_oe` is 1 for all 64 bits.
- R6: For opcodes 10 and 11, `mdio_oe` is 0 for the two turnaround bits and all 16 data bits, which are the last 18 bits of the frame.
- R7: For opcodes 10 and 11, `mdio_i` is sampled on each of the 16 rising `mdc` edges of the data field, the first sample going to bit 15. The result is on `rdata` when `done` pulses.
- R8: `busy` rises on the cycle after an accepted `start` and stays high until the last `mdc` falling edge. `done` then pulses for one clock and `mdio_oe` returns to 0.
- R9: A `start` pulse while `busy` is high is ignored. The frame in progress continues unchanged and no new frame follows.
- R10: `mdio_o` and `mdio_oe` change only at the start of a frame or together with a falling edge of `mdc`, never while `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| op | input | 2 | Frame opcode |
| port_addr | input | 5 | Port address field |
| dev_addr | input | 5 | Device address field |
| wdata | input | 16 | Payload: register address or write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rdata | output | 16 | Data captured by the last read-type frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Driver enable for MDIO |
| mdio_i | input | 1 | Sensed MDIO level |

## Verification
The hardest case to reach from the ports is a second `start` arriving in the middle of a frame, carrying different fields. A correct design shows no sign of having seen it. The bench raises such a request deep inside a read frame. It then checks that the captured wire image, the enable pattern and the read data all match the first request, and that the frame has exactly 64 clock periods. A bench-side device model counts `mdc` rising edges. It drives the turnaround zero and a known data word at the positions the edge count selects, so any error in the master's sampling edge or bit order changes `rdata`.

// File: rtl/mdio_c45_master.sv
module mdio_c45_master #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  port_addr,
  input  logic [4:0]  dev_addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic [5:0]    bitn;
  logic [63:0]   fr;
  logic          rd_flag;
  logic          oe_q;
  wire           hp_end = (cnt == CW'(HALF_DIV - 1));

  assign mdio_o  = fr[63];
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      mdc     <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      fr      <= '1;
      rd_flag <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt     <= '0;
          mdc     <= 1'b0;
          bitn    <= '0;
          fr      <= {32'hFFFF_FFFF, 2'b00, op, port_addr, dev_addr, 2'b10, wdata};
          rd_flag <= op[1];
          oe_q    <= 1'b1;
        end
      end else if (!hp_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_flag && bitn >= 6'd48)
            rdata <= {rdata[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bitn == 6'd63) begin
            busy <= 1'b0;
            done <= 1'b1;
            fr   <= '1;
            oe_q <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            fr   <= {fr[62:0], 1'b1};
            oe_q <= (bitn < 6'd45) || !rd_flag;
          end
        end
      end
    end
  end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc && mdio_o));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_flag && bitn >= 6'd46) |-> !mdio_oe);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy && $stable(rd_flag)) || done);

  assert_fall_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_c45_master_tb.sv
module mdio_c45_master_tb_top;
  localparam int HD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [4:0] port_addr = '0, dev_addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic mdio_i;

  int total = 0, fails = 0;
  int idx = 0;
  logic [63:0] cap, capoe;
  logic [15:0] rpat = '0;
  longint t0 = 0, t1 = 0;
  int viol = 0;
  logic pmdc = 1'b0, pmo = 1'b1, poe = 1'b0;

  always #5 clk = ~clk;

  mdio_c45_master #(.HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .port_addr(port_addr),
    .dev_addr(dev_addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (idx >= 48 && idx <= 63) ? rpat[63 - idx] : (idx == 47 ? 1'b0 : 1'b1);

  always @(posedge mdc) begin
    if (idx < 64) begin
      cap[63 - idx]   = mdio_o;
      capoe[63 - idx] = mdio_oe;
    end
    if (idx == 0) t0 = $time;
    if (idx == 1) t1 = $time;
    idx = idx + 1;
  end

  always @(negedge clk) begin
    if (pmdc && mdc && (mdio_o !== pmo || mdio_oe !== poe)) viol = viol + 1;
    pmdc = mdc; pmo = mdio_o; poe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] o, input logic [4:0] pa, input logic [4:0] da,
                       input logic [15:0] wd, input logic [15:0] rp, input bit poke);
    logic [63:0] exp, mask;
    idx = 0; viol = 0; rpat = rp;
    @(negedge clk);
    op = o; port_addr = pa; dev_addr = da; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", {63'b0, busy}, 64'd1);
    if (poke) begin
      repeat (150) @(negedge clk);
      op = ~o; port_addr = ~pa; dev_addr = ~da; wdata = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (done) break;
    end
    exp  = {32'hFFFF_FFFF, 2'b00, o, pa, da, 2'b10, wd};
    mask = o[1] ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    chk(idx == 64, "R2 mdc period count", 64'(idx), 64'd64);
    chk((t1 - t0) == 2 * HD * 10, "R2 mdc period length", 64'(t1 - t0), 64'(2 * HD * 10));
    chk(cap[63:30] == exp[63:30], "R3 preamble and start code", {30'b0, cap[63:30]}, {30'b0, exp[63:30]});
    chk(cap[29:18] == exp[29:18], "R4 opcode port device order", {52'b0, cap[29:18]}, {52'b0, exp[29:18]});
    if (!o[1]) chk(cap[17:0] == exp[17:0], "R5 turnaround and payload", {46'b0, cap[17:0]}, {46'b0, exp[17:0]});
    chk(capoe == mask, o[1] ? "R6 read release" : "R5 driven throughout", capoe, mask);
    if (o[1]) chk(rdata == rp, "R7 read data", {48'b0, rdata}, {48'b0, rp});
    chk(!busy && !mdio_oe && !mdc && mdio_o, "R8 release after frame",
        {60'b0, busy, mdio_oe, mdc, mdio_o}, 64'd1);
    chk(viol == 0, "R10 change only on fall", 64'(viol), 64'd0);
    @(negedge clk);
    chk(!done, "R8 done single pulse", {63'b0, done}, 64'd0);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(!busy && idx == 64, "R9 no second frame", {63'b0, busy}, 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [4:0] pats [4];
    pats[0] = 5'd0; pats[1] = 5'd31; pats[2] = 5'b10101; pats[3] = 5'b01010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe && mdio_o, "R1 reset state",
        {59'b0, busy, done, mdc, mdio_oe, mdio_o}, 64'd1);
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 4; p++)
        frame(2'(o), pats[p], pats[3 - p], 16'hA5C3 ^ 16'(p * 16'h1111),
              16'h8001 ^ 16'(o * 16'h0F0F + p * 16'h3030), 1'b0);
    frame(2'b11, 5'd9, 5'd22, 16'h1234, 16'hBEEF, 1'b1);
    frame(2'b01, 5'd17, 5'd3, 16'h7E81, 16'h0000, 1'b1);
    repeat (10) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R1 idle between frames", {61'b0, busy, mdc, mdio_oe}, 64'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule